// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block puts a packet onto a low-speed USB differential pair. The packet is already assembled, and its length is given as a byte count that includes the sync byte. The block makes the sync pattern itself. It then fetches the remaining bytes one at a time through a combinational read port. Each byte is sent least significant bit first. Every bit goes through NRZI encoding and bit stuffing before it reaches the lines.

The block drives the pair only while it transmits. On a start strobe it enables its drivers with the lines at idle J and holds them there for one bit time. It then sends the bits. After the last bit it produces the end-of-packet sequence: two bit times of SE0, then one bit time of J. Finally it tristates the lines and pulses a done strobe.

A second strobe, issued together with done, tells the surrounding logic that a pending device address may now be committed. It is issued only for data packets, never for a handshake reply. CRC generation and packet content belong to the surrounding logic.

Top module: `ls_pkt_tx`

## Requirements
- R1: When idle and after reset, `oe_o`, `dp_o`, `dm_o`, `done_o` and `addr_commit_o` are all low.
- R2: A `start_i` seen in idle raises `oe_o` in the next cycle with the lines at J (`dp_o`=0, `dm_o`=1). J is held for exactly `BIT_CLKS` clocks, so the first sync bit appears `BIT_CLKS`+1 clocks after the start edge. That is well inside the 7.5 bit-time reply limit.
- R3: Every bit window lasts exactly `BIT_CLKS` clocks. The lines change only at window boundaries.
- R4: The first byte sent is the sync byte 8'h80, generated internally. `byte_cnt_i` counts it. The following `byte_cnt_i`-1 bytes are read from buffer addresses 0, 1, 2 and so on. Every byte is sent LSB first.
- R5: NRZI: a 0 bit swaps the line between J and K, and a 1 bit leaves it unchanged. The line starts from the J preamble.
- R6: After six consecutive 1 bits, one extra window is inserted in which the line toggles, and no data bit is consumed in that window. The run count restarts on every 0 bit and on every inserted window. The rule also applies when the sixth 1 is the last bit of the packet, before end-of-packet.
- R7: After the last bit (or the last inserted window) the lines show SE0 (both low) for exactly 2 windows, then J for exactly 1 window. Then `oe_o` falls and both lines are low.
- R8: `done_o` is a single-cycle pulse in the first cycle that `oe_o` is low after a packet.
- R9: `addr_commit_o` pulses together with `done_o` only if `hs_i` was low when the packet was started. `hs_i` high marks a handshake reply (sync plus PID, `byte_cnt_i`=2), and it never produces the pulse.
- R10: `start_i`, `byte_cnt_i` and `hs_i` are ignored while a packet is in progress. The waveform in flight and the commit decision are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 12 MHz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| hs_i | input | 1 | Packet is a handshake reply (no address commit) |
| byte_cnt_i | input | CNT_W | Bytes to send, sync byte included |
| rd_addr_o | output | CNT_W | Buffer read address |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o`, combinational |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | Packet finished, one cycle |
| addr_commit_o | output | 1 | Pending device address may be committed, one cycle |

## Verification
The checker watches several properties on every cycle:
- the lines are low whenever the drivers are off;
- the bus is acquired at J and released from J;
- line changes happen only on bit-window boundaries;
- a J or K level never lasts longer than seven windows;
- every SE0 run is exactly two windows;
- done and commit are single pulses, and commit follows the handshake flag captured at start.

Only the bench scenarios can show that the bit sequence itself is right. For that, the bench computes the sync byte, the byte order, the NRZI levels and the exact positions of the inserted stuff windows for each packet, including a stuff window just before end-of-packet. The bench also checks that a start issued mid-packet changes nothing.

// File: rtl/ls_tx_pkg.sv
package ls_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_SE0,
    ST_EOPJ
  } tx_state_e;

  // encoded as {dp, dm}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10
  } line_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;

endpackage

// File: rtl/ls_tx_bit_timer.sv
module ls_tx_bit_timer #(
  parameter int BIT_CLKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  localparam int W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [W-1:0] LAST = W'(BIT_CLKS - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/ls_tx_stuffer.sv
module ls_tx_stuffer #(
  parameter int RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic step_i,
  input  logic bit_i,
  output logic stuff_o
);

  localparam int W = $clog2(RUN_LEN + 1);
  localparam logic [W-1:0] RELOAD = W'(RUN_LEN);

  logic [W-1:0] ones_q;

  // counts down the ones still allowed before a forced toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ones_q <= RELOAD;
    else if (init_i)   ones_q <= RELOAD;
    else if (step_i) begin
      if (stuff_o || !bit_i) ones_q <= RELOAD;
      else                   ones_q <= ones_q - W'(1);
    end
  end

  assign stuff_o = (ones_q == '0);

endmodule

// File: rtl/ls_tx_line_drv.sv
module ls_tx_line_drv
  import ls_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acquire_i,
  input  logic toggle_i,
  input  logic se0_i,
  input  logic restore_j_i,
  input  logic release_i,
  output logic dp_o,
  output logic dm_o,
  output logic oe_o
);

  line_e line_q;
  logic  oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= LN_SE0;
      oe_q   <= 1'b0;
    end else if (release_i) begin
      line_q <= LN_SE0;
      oe_q   <= 1'b0;
    end else if (acquire_i) begin
      line_q <= LN_J;
      oe_q   <= 1'b1;
    end else if (se0_i) begin
      line_q <= LN_SE0;
    end else if (restore_j_i) begin
      line_q <= LN_J;
    end else if (toggle_i) begin
      line_q <= (line_q == LN_J) ? LN_K : LN_J;
    end
  end

  assign dp_o = line_q[1];
  assign dm_o = line_q[0];
  assign oe_o = oe_q;

endmodule

// File: rtl/ls_pkt_tx.sv
module ls_pkt_tx
  import ls_tx_pkg::*;
#(
  parameter int BIT_CLKS = 8,
  parameter int CNT_W    = 5,
  parameter int RUN_LEN  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hs_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  output logic [CNT_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             dp_o,
  output logic             dm_o,
  output logic             oe_o,
  output logic             done_o,
  output logic             addr_commit_o
);

  tx_state_e        state_q;
  logic [7:0]       shift_q;
  logic [2:0]       bit_idx_q;
  logic [CNT_W-1:0] byte_idx_q;
  logic [CNT_W-1:0] last_idx_q;
  logic             fin_q;
  logic             half_q;
  logic             hs_q;
  logic             done_q;
  logic             commit_q;

  logic tick;
  logic stuff;
  logic run;
  logic start_ok;
  logic in_bits;
  logic do_stuff;
  logic do_end;
  logic do_bit;
  logic cur_bit;
  logic byte_last;
  logic se0_done;
  logic eop_done;

  assign run       = (state_q != ST_IDLE);
  assign start_ok  = (state_q == ST_IDLE) && start_i;
  assign in_bits   = ((state_q == ST_PRE) || (state_q == ST_DATA)) && tick;
  assign do_stuff  = in_bits && stuff;
  assign do_end    = in_bits && !stuff && fin_q;
  assign do_bit    = in_bits && !stuff && !fin_q;
  assign cur_bit   = shift_q[0];
  assign byte_last = (bit_idx_q == 3'd7);
  assign se0_done  = tick && (state_q == ST_SE0) && half_q;
  assign eop_done  = tick && (state_q == ST_EOPJ);

  // buffer holds packet bytes 1..N-1 at 0..N-2
  assign rd_addr_o = byte_idx_q;

  ls_tx_bit_timer #(
    .BIT_CLKS(BIT_CLKS)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  ls_tx_stuffer #(
    .RUN_LEN(RUN_LEN)
  ) u_stuff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (start_ok),
    .step_i (do_stuff | do_bit),
    .bit_i  (cur_bit),
    .stuff_o(stuff)
  );

  ls_tx_line_drv u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acquire_i  (start_ok),
    .toggle_i   (do_stuff | (do_bit & ~cur_bit)),
    .se0_i      (do_end),
    .restore_j_i(se0_done),
    .release_i  (eop_done),
    .dp_o       (dp_o),
    .dm_o       (dm_o),
    .oe_o       (oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      shift_q    <= '0;
      bit_idx_q  <= '0;
      byte_idx_q <= '0;
      last_idx_q <= '0;
      fin_q      <= 1'b0;
      half_q     <= 1'b0;
      hs_q       <= 1'b0;
    end else begin
      if (start_ok) begin
        state_q    <= ST_PRE;
        shift_q    <= SYNC_BYTE;
        bit_idx_q  <= '0;
        byte_idx_q <= '0;
        last_idx_q <= (byte_cnt_i == '0) ? '0 : byte_cnt_i - CNT_W'(1);
        fin_q      <= 1'b0;
        half_q     <= 1'b0;
        hs_q       <= hs_i;
      end
      if (in_bits) state_q <= ST_DATA;
      if (do_bit) begin
        if (byte_last) begin
          bit_idx_q <= '0;
          if (byte_idx_q == last_idx_q) begin
            fin_q <= 1'b1;
          end else begin
            shift_q    <= rd_data_i;
            byte_idx_q <= byte_idx_q + CNT_W'(1);
          end
        end else begin
          shift_q   <= {1'b0, shift_q[7:1]};
          bit_idx_q <= bit_idx_q + 3'd1;
        end
      end
      if (do_end) begin
        state_q <= ST_SE0;
        half_q  <= 1'b0;
      end
      if (tick && (state_q == ST_SE0)) begin
        if (!half_q) half_q  <= 1'b1;
        else         state_q <= ST_EOPJ;
      end
      if (eop_done) state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      done_q   <= eop_done;
      commit_q <= eop_done && !hs_q;
    end
  end

  assign done_o        = done_q;
  assign addr_commit_o = commit_q;

endmodule

// File: rtl/ls_pkt_tx_chk.sv
module ls_pkt_tx_chk #(
  parameter int BIT_CLKS = 8,
  parameter int RUN_LEN  = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic hs_i,
  input logic dp_o,
  input logic dm_o,
  input logic oe_o,
  input logic done_o,
  input logic addr_commit_o
);

  localparam int MAX_RUN = (RUN_LEN + 1) * BIT_CLKS;
  localparam int RW = $clog2(MAX_RUN + 2);
  localparam int PW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int SW = $clog2(2 * BIT_CLKS + 2);

  logic [1:0]    line;
  logic [PW-1:0] phase_q;
  logic [RW-1:0] run_q;
  logic [SW-1:0] se0_q;
  logic [1:0]    line_prev_q;
  logic          hs_seen_q;

  assign line = {dp_o, dm_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= '0;
      run_q       <= '0;
      se0_q       <= '0;
      line_prev_q <= 2'b00;
      hs_seen_q   <= 1'b0;
    end else begin
      line_prev_q <= line;
      if (!oe_o)                            phase_q <= '0;
      else if (phase_q == PW'(BIT_CLKS-1))  phase_q <= '0;
      else                                  phase_q <= phase_q + PW'(1);
      if (!oe_o || line == 2'b00 || line != line_prev_q) run_q <= '0;
      else if (run_q != '1)                              run_q <= run_q + RW'(1);
      if (oe_o && line == 2'b00) se0_q <= se0_q + SW'(1);
      else                       se0_q <= '0;
      if (start_i && !oe_o) hs_seen_q <= hs_i;
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (!dp_o && !dm_o));

  assert_start_acquires_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !oe_o) |=> oe_o);

  assert_acquire_j_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> (!dp_o && dm_o));

  assert_bit_boundary_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && $past(oe_o) && line != $past(line)) |-> phase_q == '0);

  assert_max_level_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> run_q < RW'(MAX_RUN));

  assert_se0_length_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && line == 2'b01 && $past(oe_o) && $past(line) == 2'b00) |-> se0_q == SW'(2 * BIT_CLKS));

  assert_release_from_j_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> ($past(dm_o) && !$past(dp_o)));

  assert_done_on_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> done_o);

  assert_done_needs_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(oe_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_commit_data_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_commit_o |-> (done_o && !hs_seen_q));

  assert_commit_given_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hs_seen_q) |-> addr_commit_o);

endmodule

bind ls_pkt_tx ls_pkt_tx_chk #(
  .BIT_CLKS(BIT_CLKS),
  .RUN_LEN (RUN_LEN)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .hs_i         (hs_i),
  .dp_o         (dp_o),
  .dm_o         (dm_o),
  .oe_o         (oe_o),
  .done_o       (done_o),
  .addr_commit_o(addr_commit_o)
);

// File: tb/ls_pkt_tx_tb_top.sv
module ls_pkt_tx_tb_top;

  localparam int BIT_CLKS = 8;
  localparam int CNT_W    = 5;
  localparam logic [1:0] L_J   = 2'b01;
  localparam logic [1:0] L_K   = 2'b10;
  localparam logic [1:0] L_SE0 = 2'b00;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             start_i;
  logic             hs_i;
  logic [CNT_W-1:0] byte_cnt_i;
  logic [CNT_W-1:0] rd_addr_o;
  logic [7:0]       rd_data_i;
  logic             dp_o, dm_o, oe_o, done_o, addr_commit_o;

  logic [7:0] mem [0:31];
  logic [1:0] exp_q [0:511];
  int n_win;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  assign rd_data_i = mem[rd_addr_o];

  ls_pkt_tx #(.BIT_CLKS(BIT_CLKS), .CNT_W(CNT_W), .RUN_LEN(6)) dut_i (
    .clk_i, .rst_ni, .start_i, .hs_i, .byte_cnt_i, .rd_addr_o, .rd_data_i,
    .dp_o, .dm_o, .oe_o, .done_o, .addr_commit_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] flip(input logic [1:0] l);
    return (l == L_J) ? L_K : L_J;
  endfunction

  // expected level per bit window: preamble, stuffed NRZI bits, EOP
  task automatic build(input int cnt);
    logic [1:0] lvl;
    logic [7:0] by;
    int ones;
    n_win = 0;
    lvl = L_J;
    exp_q[n_win] = lvl; n_win++;
    ones = 0;
    for (int i = 0; i < cnt; i++) begin
      by = (i == 0) ? 8'h80 : mem[i-1];
      for (int k = 0; k < 8; k++) begin
        if (!by[k]) lvl = flip(lvl);
        exp_q[n_win] = lvl; n_win++;
        if (by[k]) ones++; else ones = 0;
        if (ones == 6) begin
          lvl = flip(lvl);
          exp_q[n_win] = lvl; n_win++;
          ones = 0;
        end
      end
    end
    exp_q[n_win] = L_SE0; n_win++;
    exp_q[n_win] = L_SE0; n_win++;
    exp_q[n_win] = L_J;   n_win++;
  endtask

  task automatic send(input int cnt, input bit hs, input int glitch_win, input string name);
    string rq;
    build(cnt);
    @(negedge clk_i);
    start_i = 1'b1; byte_cnt_i = CNT_W'(cnt); hs_i = hs;
    @(negedge clk_i);
    start_i = 1'b0; byte_cnt_i = CNT_W'(3); hs_i = ~hs;
    for (int w = 0; w < n_win; w++) begin
      if (w == 0)              rq = "R2";
      else if (w >= n_win - 3) rq = "R7";
      else                     rq = "R5";
      for (int c = 0; c < BIT_CLKS; c++) begin
        if (c == 0) begin
          check($sformatf("%s %s win%0d level", rq, name, w), {30'd0, dp_o, dm_o}, {30'd0, exp_q[w]});
          check($sformatf("%s %s win%0d oe", rq, name, w), {31'd0, oe_o}, 32'd1);
        end
        if (c == BIT_CLKS - 1)
          check($sformatf("R3 %s win%0d end level", name, w), {30'd0, dp_o, dm_o}, {30'd0, exp_q[w]});
        if (w == glitch_win && c == 2) start_i = 1'b1;
        if (w == glitch_win && c == 3) start_i = 1'b0;
        @(negedge clk_i);
      end
    end
    check($sformatf("R7 %s released oe", name), {31'd0, oe_o}, 32'd0);
    check($sformatf("R7 %s released lines", name), {30'd0, dp_o, dm_o}, 32'd0);
    check($sformatf("R8 %s done", name), {31'd0, done_o}, 32'd1);
    check($sformatf("R9 %s commit", name), {31'd0, addr_commit_o}, {31'd0, ~hs});
    @(negedge clk_i);
    check($sformatf("R8 %s done single", name), {31'd0, done_o}, 32'd0);
    check($sformatf("R9 %s commit single", name), {31'd0, addr_commit_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    rst_ni = 1'b0; start_i = 1'b0; hs_i = 1'b0; byte_cnt_i = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset oe", {31'd0, oe_o}, 32'd0);
    check("R1 reset lines", {30'd0, dp_o, dm_o}, 32'd0);
    check("R1 reset strobes", {30'd0, done_o, addr_commit_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle oe", {31'd0, oe_o}, 32'd0);

    // handshake reply: sync + PID
    mem[0] = 8'hD2;
    send(2, 1'b1, -1, "R9 handshake");

    mem[0] = 8'hC3; mem[1] = 8'h11; mem[2] = 8'h22; mem[3] = 8'h33; mem[4] = 8'h44;
    send(6, 1'b0, -1, "R4 data");

    for (int i = 0; i < 4; i++) mem[i] = 8'hFF;
    send(5, 1'b0, -1, "R6 ones");

    // six ones end the packet: stuffed window before SE0
    mem[0] = 8'hFC;
    send(2, 1'b0, -1, "R6 tail stuff");

    for (int i = 0; i < 7; i++) mem[i] = 8'(8'h5A + i * 8'h13);
    send(8, 1'b0, 5, "R10 busy start");
    send(8, 1'b1, 20, "R10 busy start hs");

    for (int v = 0; v < 256; v++) begin
      mem[0] = 8'(v);
      mem[1] = ~8'(v);
      send(3, v[0], -1, "R4 sweep");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule